// File: doc/BRIEF.md
# Sector Page-Load Program Controller

This block models the write side of a sector-organised flash memory. A host issues byte writes on a synchronous port. Each write is a cycle in which chip enable and write enable are active and output enable is inactive. The block gathers those writes into a one-sector page buffer. The first write of a sequence freezes the sector address. Later writes pick a byte inside that sector, in any order, and may overwrite a byte that was already loaded.

Loading ends when no write has been accepted for a set number of clock cycles. At that point the block enters a busy phase of fixed length. At the end of the busy phase the whole sector is committed to a behavioural memory array in one step. Bytes that were not loaded are written as FF. The load window and the busy length are parameters in clock cycles. The array holds a parameterised number of sectors, which keeps elaboration small. While the block is not busy, the host can read the array with a one-cycle registered read.

Top module: `sector_load_prog`

## Requirements
- R1: After reset, `busy` is 0, `rdata` is 0, and every array byte reads FF.
- R2: A write is accepted only in a cycle where `ce_n`=0, `we_n`=0 and `oe_n`=1. A cycle with any other combination loads nothing and does not start a load sequence.
- R3: The sector number (address bits 16:7) is taken from the first accepted write of a sequence. Later writes in the same sequence use only address bits 6:0, and their upper bits are ignored.
- R4: Bytes may be loaded in any order. A byte written more than once in a sequence takes the last value written.
- R5: `busy` rises LOAD_TIMEOUT cycles after the last accepted write, if no write is accepted in between. Each accepted write restarts this window.
- R6: At commit, every byte of the latched sector that was not loaded in the sequence becomes FF.
- R7: `busy` stays high for exactly PROG_CYCLES cycles. All loaded bytes reach the array together when it falls, and no other sector changes.
- R8: Writes presented while `busy` is high are ignored. They neither load bytes nor start a new sequence.
- R9: When `ce_n`=0, `oe_n`=0 and `busy`=0, `rdata` shows the array byte at `addr` one cycle later. In any other cycle `rdata` holds its value.
- R10: The array index is (sector mod 2^ARR_SECT_W)·128 + (address bits 6:0), for both reads and commits. Sector numbers that differ only above that width therefore alias the same array sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address: bits 16:7 sector, bits 6:0 byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High during the internal program phase |

## Verification
The bench builds the block with LOAD_TIMEOUT=6, PROG_CYCLES=12 and ARR_SECT_W=2. That gives a 512-byte array which the bench reads back in full after every program phase, so the exact edge where `busy` rises and falls can be counted cycle by cycle. With four array sectors, sector numbers 2 and 6 fall on the same storage, so aliasing is exercised. With the short window, gaps of one cycle below the timeout can prove that a write restarts the window.

// File: rtl/sector_prog_pkg.sv
package sector_prog_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;

  // flat array position of a byte: sector folded onto the stored sectors
  function automatic int flat_index(input int sect, input int off,
                                    input int sect_bits, input int offs_bits);
    return ((sect % (1 << sect_bits)) << offs_bits) + off;
  endfunction

endpackage

// File: rtl/slp_write_qual.sv
module slp_write_qual (
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic busy,
  output logic wr_acc,
  output logic rd_en
);
  // write needs output enable parked high; nothing is taken while busy
  assign wr_acc = !ce_n && !we_n && oe_n && !busy;
  assign rd_en  = !ce_n && !oe_n && !busy;
endmodule

// File: rtl/slp_sequencer.sv
module slp_sequencer
  import sector_prog_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 15000,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_acc,
  output phase_t phase,
  output logic   expire,
  output logic   commit,
  output logic   busy
);
  localparam int CNT_MAX = (LOAD_TIMEOUT > PROG_CYCLES) ? LOAD_TIMEOUT : PROG_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire = (phase_q == PH_LOAD) && !wr_acc && (cnt_q == CNT_W'(LOAD_TIMEOUT - 1));
  assign commit = (phase_q == PH_PROG) && (cnt_q == CNT_W'(PROG_CYCLES - 1));
  assign busy   = (phase_q == PH_PROG);
  assign phase  = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (wr_acc) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
          end
        end
        PH_LOAD: begin
          if (wr_acc) begin
            cnt_q <= '0;
          end else if (expire) begin
            phase_q <= PH_PROG;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PROG: begin
          if (commit) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/slp_page_buf.sv
module slp_page_buf #(
  parameter int OFFS_W = 7,
  parameter int SECT_W = 10,
  parameter int DATA_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_acc,
  input  logic                                 first,
  input  logic                                 clear,
  input  logic [OFFS_W-1:0]                    wr_off,
  input  logic [SECT_W-1:0]                    wr_sect,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [SECT_W-1:0]                    sect_q,
  output logic [(1<<OFFS_W)-1:0][DATA_W-1:0]   page_q,
  output logic [(1<<OFFS_W)-1:0]               loaded_q
);
  localparam int PAGE = 1 << OFFS_W;

  // sector number frozen by the opening write of a sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q <= '0;
    end else if (wr_acc && first) begin
      sect_q <= wr_sect;
    end
  end

  // one flag per byte; cleared when the page is committed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
    end else if (clear) begin
      loaded_q <= '0;
    end else if (wr_acc) begin
      loaded_q[wr_off] <= 1'b1;
    end
  end

  // data holders need no reset: unflagged bytes are never used
  for (genvar g = 0; g < PAGE; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (wr_acc && (wr_off == OFFS_W'(g))) begin
        page_q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/slp_array.sv
module slp_array
  import sector_prog_pkg::*;
#(
  parameter int ARR_SECT_W = 3,
  parameter int OFFS_W     = 7,
  parameter int SECT_W     = 10,
  parameter int DATA_W     = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                commit,
  input  logic [SECT_W-1:0]                   commit_sect,
  input  logic [(1<<OFFS_W)-1:0][DATA_W-1:0]  page,
  input  logic [(1<<OFFS_W)-1:0]              loaded,
  input  logic                                rd_en,
  input  logic [ARR_SECT_W+OFFS_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]                   rdata
);
  localparam int PAGE      = 1 << OFFS_W;
  localparam int IDX_W     = ARR_SECT_W + OFFS_W;
  localparam int ARR_BYTES = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [ARR_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_BYTES; i++) mem_q[i] <= {DATA_W{1'b1}};
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        mem_q[IDX_W'(flat_index(int'(commit_sect), i, ARR_SECT_W, OFFS_W))]
          <= loaded[i] ? page[i] : {DATA_W{1'b1}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= mem_q[rd_idx];
    end
  end
endmodule

// File: rtl/sector_load_prog.sv
module sector_load_prog
  import sector_prog_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int OFFS_W       = 7,
  parameter int ARR_SECT_W   = 3,
  parameter int LOAD_TIMEOUT = 15000,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int SECT_W = ADDR_W - OFFS_W;
  localparam int PAGE   = 1 << OFFS_W;
  localparam int IDX_W  = ARR_SECT_W + OFFS_W;

  // named internal events, observed by the bound checker
  logic                         wr_acc;
  logic                         rd_en;
  logic                         expire;
  logic                         commit;
  logic                         loading;
  phase_t                       phase;
  logic [SECT_W-1:0]            sect_q;
  logic [PAGE-1:0][DATA_W-1:0]  page_q;
  logic [PAGE-1:0]              loaded_q;
  logic [IDX_W-1:0]             rd_idx;

  assign loading = (phase == PH_LOAD);
  assign rd_idx  = IDX_W'(flat_index(int'(addr[ADDR_W-1:OFFS_W]),
                                     int'(addr[OFFS_W-1:0]), ARR_SECT_W, OFFS_W));

  slp_write_qual qual_i (
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .busy   (busy),
    .wr_acc (wr_acc),
    .rd_en  (rd_en)
  );

  slp_sequencer #(
    .LOAD_TIMEOUT (LOAD_TIMEOUT),
    .PROG_CYCLES  (PROG_CYCLES)
  ) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_acc (wr_acc),
    .phase  (phase),
    .expire (expire),
    .commit (commit),
    .busy   (busy)
  );

  slp_page_buf #(
    .OFFS_W (OFFS_W),
    .SECT_W (SECT_W),
    .DATA_W (DATA_W)
  ) buf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_acc   (wr_acc),
    .first    (phase == PH_IDLE),
    .clear    (commit),
    .wr_off   (addr[OFFS_W-1:0]),
    .wr_sect  (addr[ADDR_W-1:OFFS_W]),
    .wdata    (wdata),
    .sect_q   (sect_q),
    .page_q   (page_q),
    .loaded_q (loaded_q)
  );

  slp_array #(
    .ARR_SECT_W (ARR_SECT_W),
    .OFFS_W     (OFFS_W),
    .SECT_W     (SECT_W),
    .DATA_W     (DATA_W)
  ) arr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_sect (sect_q),
    .page        (page_q),
    .loaded      (loaded_q),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .rdata       (rdata)
  );
endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
  parameter int PROG_CYCLES = 500000,
  parameter int SECT_W      = 10,
  parameter int DATA_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              expire,
  input logic              commit,
  input logic              wr_acc,
  input logic              loading,
  input logic [SECT_W-1:0] sect_q,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata
);
  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  a_r5_expire_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> busy);
  a_r5_busy_only_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(expire));
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == PROG_CYCLES));
  a_r7_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  a_r8_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_acc);
  a_r3_sector_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && $past(loading)) |-> $stable(sect_q));
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind sector_load_prog slp_checker #(
  .PROG_CYCLES (PROG_CYCLES),
  .SECT_W      (SECT_W),
  .DATA_W      (DATA_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .expire  (expire),
  .commit  (commit),
  .wr_acc  (wr_acc),
  .loading (loading),
  .sect_q  (sect_q),
  .rd_en   (rd_en),
  .rdata   (rdata)
);

// File: tb/sector_load_prog_tb.sv
module sector_load_prog_tb_top;
  localparam int LT   = 6;
  localparam int PC   = 12;
  localparam int ASW  = 2;
  localparam int NARR = (1 << ASW) * 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] exp_mem [NARR];
  logic [7:0] m_buf [128];
  bit         m_ld [128];
  int         m_sect;
  bit         m_loading;

  always #10 clk = ~clk;

  sector_load_prog #(.ARR_SECT_W(ASW), .LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  function automatic int idx_of(input int a);
    return (((a >> 7) % (1 << ASW)) * 128) + (a % 128);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one strobe cycle; the bench model records it only if it should be taken
  task automatic do_write(input int a, input int d, input bit c, input bit w, input bit o);
    @(negedge clk);
    addr = 17'(a); wdata = 8'(d); ce_n = c; we_n = w; oe_n = o;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    if (!c && !w && o) begin
      if (!m_loading) begin m_loading = 1; m_sect = a >> 7; end
      m_buf[a % 128] = 8'(d);
      m_ld[a % 128]  = 1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(input int a, input string req);
    @(negedge clk);
    addr = 17'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    check(req, int'(rdata), int'(exp_mem[idx_of(a)]));
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < NARR; a++) read_chk(a, req);
  endtask

  // called right after the last write; times the window and the busy phase
  task automatic finish_prog(input bit poke);
    int n;
    for (int j = 1; j <= LT; j++) begin
      @(negedge clk);
      check("R5 busy onset", int'(busy), (j == LT) ? 1 : 0);
    end
    n = 1;
    if (poke) begin
      addr = 17'h00000; wdata = 8'h5A; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    end
    forever begin
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      if (busy) n++;
      else break;
    end
    check("R7 busy length", n, PC);
    for (int i = 0; i < 128; i++) begin
      exp_mem[idx_of(m_sect * 128 + i)] = m_ld[i] ? m_buf[i] : 8'hFF;
      m_ld[i] = 0;
    end
    m_loading = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NARR; i++) exp_mem[i] = 8'hFF;
    for (int i = 0; i < 128; i++) m_ld[i] = 0;
    m_loading = 0; m_sect = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 rdata after reset", int'(rdata), 0);
    sweep("R1 array FF");

    // R2: illegal strobe combinations take nothing
    do_write(16, 8'h33, 1'b0, 1'b0, 1'b0);
    do_write(17, 8'h34, 1'b1, 1'b0, 1'b1);
    do_write(18, 8'h35, 1'b0, 1'b1, 1'b1);
    idle(LT + 3);
    check("R2 no load started", int'(busy), 0);
    read_chk(16, "R2 byte untouched");
    read_chk(17, "R2 byte untouched");

    // full sector 1, reverse order
    for (int i = 127; i >= 0; i--) do_write(128 + i, (i * 37 + 11) & 8'hFF, 1'b0, 1'b0, 1'b1);
    finish_prog(0);
    sweep("R4 R7 full sector");

    // sector 2 frozen, upper bits varied, gaps just under the window
    do_write(2 * 128 + 5, 8'h11, 1'b0, 1'b0, 1'b1);
    idle(LT - 2);
    check("R5 window restart", int'(busy), 0);
    do_write(3 * 128 + 9, 8'h99, 1'b0, 1'b0, 1'b1);
    idle(LT - 2);
    check("R5 window restart", int'(busy), 0);
    do_write(5 * 128 + 20, 8'hC4, 1'b0, 1'b0, 1'b1);
    idle(LT - 2);
    do_write(7 * 128 + 5, 8'h22, 1'b0, 1'b0, 1'b1);
    m_sect = 2;
    finish_prog(1);
    idle(LT + 3);
    check("R8 busy write ignored", int'(busy), 0);
    read_chk(0, "R8 busy write ignored");
    read_chk(2 * 128 + 5, "R4 overwrite last wins");
    read_chk(3 * 128 + 9, "R3 upper bits ignored");
    read_chk(2 * 128 + 50, "R6 unloaded FF");
    sweep("R3 R6 partial sector");

    // sector 6 lands on array sector 2
    do_write(6 * 128 + 0, 8'hA1, 1'b0, 1'b0, 1'b1);
    do_write(6 * 128 + 127, 8'hB2, 1'b0, 1'b0, 1'b1);
    finish_prog(0);
    read_chk(2 * 128 + 9, "R10 alias clears old data");
    read_chk(6 * 128 + 127, "R10 alias read");
    read_chk(2 * 128 + 0, "R10 alias write");
    sweep("R10 R6 aliased sector");

    // R9: rdata holds without a read strobe
    read_chk(2 * 128 + 0, "R9 read");
    addr = 17'(2 * 128 + 127);
    idle(3);
    check("R9 rdata holds", int'(rdata), int'(exp_mem[2 * 128 + 0]));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule